// File: doc/BRIEF.md
# Dual-Range Periodic Tick Timer

A free-running interval timer that raises a sticky, active-low tick each time a programmable period elapses. A divider turns the system clock into a 0.2 ms base pulse. A range select bit and a 2-bit length code then choose one of eight periods. Each period is a whole number of base pulses. The tick stays low until software gives a rising edge on the clear control. A maskable interrupt request and a status bit follow the tick.

Expiries fall on a fixed grid. The grid starts at reset release, or at the cycle in which the range or length code changes. Clearing the tick never moves the grid. An expiry that arrives while the tick is already low leaves it low, and no second event is recorded.

Top module: `tick_timer`

## Requirements
- R1: With `fast_i`=1, `len_i` values 0,1,2,3 select 1, 2, 10 and 20 base periods (0.2, 0.4, 2.0 and 4.0 ms). With `fast_i`=0 they select 25, 50, 250 and 500 base periods (5, 10, 50 and 100 ms). One base period is `BASE_DIV` clock cycles.
- R2: After reset release, expiries occur on every N·`BASE_DIV`-th rising clock edge, where N is the selected multiple. The first expiry is at edge N·`BASE_DIV`.
- R3: At an expiry `tick_no` goes to 0 at that clock edge and stays 0 until it is cleared.
- R4: The tick is cleared only by a 0-to-1 change of `clr_i` sampled at a clock edge. Holding `clr_i` at 1 does not clear a tick raised by a later expiry.
- R5: A clear does not restart the interval. The next expiry still falls on the original grid.
- R6: If an expiry and a clear rise fall on the same edge, the tick stays asserted.
- R7: An expiry while the tick is already asserted leaves it asserted. A single clear afterwards releases it.
- R8: `irq_o` is 1 exactly when the tick is asserted and the registered enable is 1. The enable samples `irq_en_i` at each edge and resets to 1.
- R9: `tick_stat_o` reads 1 while the tick is asserted and 0 otherwise.
- R10: During reset `tick_no`=1, `irq_o`=0 and `tick_stat_o`=0.
- R11: A change of `fast_i` or `len_i` restarts the period count at that edge and produces no expiry there. The first expiry under the new setting falls N·`BASE_DIV` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Range select: 1 fast, 0 normal |
| len_i | input | 2 | Period length code within the range |
| clr_i | input | 1 | Clear control, acts on its rising edge |
| irq_en_i | input | 1 | Interrupt request enable |
| tick_no | output | 1 | Sticky tick, active low |
| irq_o | output | 1 | Interrupt request, active high |
| tick_stat_o | output | 1 | Tick status, 1 while asserted |

## Verification
The assertions check the following on every cycle:
- the exact spacing of expiries, measured by their own cycle counter;
- that an expiry sets the tick and that only an expiry can set it;
- that a lone clear rise releases the tick;
- that a configuration change suppresses an expiry;
- that the interrupt request needs both the tick and the enable.

Other behaviours need the bench's scenarios:
- the absolute period for each of the eight codes;
- the grid surviving a mid-period clear;
- a held-high clear having no effect;
- a clear that coincides with an expiry;
- an expiry that lands on an already-asserted tick.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned MAX_MULT = 500;
  localparam int unsigned MULT_W   = $clog2(MAX_MULT + 1);

  typedef struct packed {
    logic       fast;
    logic [1:0] len;
  } tick_cfg_t;

  // period length in 0.2 ms base units
  function automatic logic [MULT_W-1:0] base_mult(input tick_cfg_t c);
    logic [MULT_W-1:0] m;
    case ({c.fast, c.len})
      3'b100:  m = MULT_W'(1);
      3'b101:  m = MULT_W'(2);
      3'b110:  m = MULT_W'(10);
      3'b111:  m = MULT_W'(20);
      3'b000:  m = MULT_W'(25);
      3'b001:  m = MULT_W'(50);
      3'b010:  m = MULT_W'(250);
      default: m = MULT_W'(500);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned BASE_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic base_o
);
  localparam int unsigned PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == PRE_LAST);
  assign base_o = wrap && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_interval.sv
module tick_interval
  import tick_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tick_cfg_t cfg_i,
  input  logic      base_i,
  output logic      expire_o,
  output logic      cfg_chg_o
);
  tick_cfg_t         cfg_q;
  logic [MULT_W-1:0] cnt_q;
  logic [MULT_W-1:0] last;

  assign cfg_chg_o = (cfg_i != cfg_q);
  assign last      = base_mult(cfg_q) - 1'b1;
  assign expire_o  = base_i && !cfg_chg_o && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (cfg_chg_o) begin
      cfg_q <= cfg_i;
      cnt_q <= '0;
    end else if (base_i) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o,
  output logic irq_o
);
  logic clr_q, en_q, tick_q;
  logic clr_rise;

  assign clr_rise = clr_i && !clr_q;
  assign tick_o   = tick_q;
  assign irq_o    = tick_q && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q  <= 1'b0;
      en_q   <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      clr_q <= clr_i;
      en_q  <= en_i;
      // expiry wins over a coincident clear
      if (expire_i)      tick_q <= 1'b1;
      else if (clr_rise) tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned BASE_DIV = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_i,
  input  logic [1:0] len_i,
  input  logic       clr_i,
  input  logic       irq_en_i,
  output logic       tick_no,
  output logic       irq_o,
  output logic       tick_stat_o
);
  tick_cfg_t cfg;
  logic      base_tick, expire, cfg_chg, tick;

  assign cfg.fast = fast_i;
  assign cfg.len  = len_i;

  tick_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_chg),
    .base_o   (base_tick)
  );

  tick_interval u_ivl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .base_i   (base_tick),
    .expire_o (expire),
    .cfg_chg_o(cfg_chg)
  );

  tick_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_i(expire),
    .clr_i   (clr_i),
    .en_i    (irq_en_i),
    .tick_o  (tick),
    .irq_o   (irq_o)
  );

  assign tick_no     = !tick;
  assign tick_stat_o = tick;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_pkg::*;
#(
  parameter int unsigned BASE_DIV = 50000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fast_i,
  input logic [1:0] len_i,
  input logic       clr_i,
  input logic       irq_en_i,
  input logic       tick_no,
  input logic       irq_o,
  input logic       expire_i,
  input logic       cfg_chg_i
);
  int unsigned cyc_q;
  logic        clr_prev_q;
  tick_cfg_t   cfg_now;

  assign cfg_now.fast = fast_i;
  assign cfg_now.len  = len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q      <= 0;
      clr_prev_q <= 1'b0;
    end else begin
      clr_prev_q <= clr_i;
      cyc_q      <= (expire_i || cfg_chg_i) ? 0 : cyc_q + 1;
    end
  end

  // R2
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |-> (cyc_q == int'(base_mult(cfg_now)) * BASE_DIV - 1));

  // R3
  tick_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> !tick_no);

  // R3
  tick_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tick_no) |-> $past(expire_i));

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !clr_prev_q && !expire_i) |=> tick_no);

  // R11
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg_i |-> !expire_i);

  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !tick_no);
endmodule

bind tick_timer tick_timer_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fast_i   (fast_i),
  .len_i    (len_i),
  .clr_i    (clr_i),
  .irq_en_i (irq_en_i),
  .tick_no  (tick_no),
  .irq_o    (irq_o),
  .expire_i (expire),
  .cfg_chg_i(cfg_chg)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 1'b0, clr = 1'b0, en = 1'b1;
  logic [1:0] len = 2'd0;
  logic tick_n, irq, stat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer #(.BASE_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast), .len_i(len), .clr_i(clr),
    .irq_en_i(en), .tick_no(tick_n), .irq_o(irq), .tick_stat_o(stat)
  );

  function automatic int np(input bit f, input bit [1:0] l);
    int m;
    if (f) m = (l == 0) ? 1 : (l == 1) ? 2 : (l == 2) ? 10 : 20;
    else   m = (l == 0) ? 25 : (l == 1) ? 50 : (l == 2) ? 250 : 500;
    return m * DIV;
  endfunction

  // spec model: one phase counter per period
  int       m_ph;
  bit [2:0] m_cfg;
  bit       m_tick, m_clr, m_en, m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cfg <= '0; m_tick <= 1'b0; m_clr <= 1'b0; m_en <= 1'b1;
    end else begin
      m_exp = 1'b0;
      if ({fast, len} != m_cfg) begin
        m_cfg <= {fast, len}; m_ph <= 0;
      end else if (m_ph == np(m_cfg[2], m_cfg[1:0]) - 1) begin
        m_exp = 1'b1; m_ph <= 0;
      end else m_ph <= m_ph + 1;
      m_clr <= clr;
      m_en  <= en;
      if (m_exp) m_tick <= 1'b1;
      else if (clr && !m_clr) m_tick <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(tick_n === !m_tick, "R3", int'(tick_n), int'(!m_tick));
    chk(stat === m_tick, "R9", int'(stat), int'(m_tick));
    chk(irq === (m_tick && m_en), "R8", int'(irq), int'(m_tick && m_en));
  endtask

  task automatic measure(input bit f, input bit [1:0] l, input string tag);
    int n;
    fast = f; len = l; clr = 1'b1;
    step(); n = 1; clr = 1'b0;
    while (tick_n !== 1'b0 && n < 3000) begin step(); n++; end
    chk(n == np(f, l) + 1, tag, n, np(f, l) + 1);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    step(); step();
    chk(tick_n === 1'b1, "R10", int'(tick_n), 1);
    chk(irq === 1'b0, "R10", int'(irq), 0);
    chk(stat === 1'b0, "R10", int'(stat), 0);
    rst_n = 1'b1;
    n = 0;
    while (tick_n !== 1'b0 && n < 3000) begin step(); n++; end
    chk(n == np(0, 0), "R2", n, np(0, 0));
    chk(irq === 1'b1, "R8", int'(irq), 1);
    chk(stat === 1'b1, "R9", int'(stat), 1);
    // R7: pass another expiry, then one clear releases
    repeat (150) step();
    chk(tick_n === 1'b0, "R7", int'(tick_n), 0);
    clr = 1'b1; step(); clr = 1'b0;
    chk(tick_n === 1'b1, "R7", int'(tick_n), 1);
    // R1 / R11: every code, each changed mid-period
    measure(1, 0, "R1");
    measure(1, 2, "R11");
    measure(1, 3, "R1");
    measure(0, 0, "R1");
    measure(0, 1, "R1");
    measure(0, 2, "R1");
    measure(0, 3, "R1");
    measure(1, 1, "R1");
    // R5: mid-period clear keeps the grid (NP=8, falls at 9, 17)
    n = 9;
    repeat (2) begin step(); n++; end
    clr = 1'b1; step(); n++; clr = 1'b0;
    chk(tick_n === 1'b1, "R4", int'(tick_n), 1);
    while (tick_n !== 1'b0 && n < 100) begin step(); n++; end
    chk(n == 2 * np(1, 1) + 1, "R5", n, 2 * np(1, 1) + 1);
    // R4: held-high clear does not clear a later expiry
    clr = 1'b1;
    repeat (10) step();
    chk(tick_n === 1'b0, "R4", int'(tick_n), 0);
    clr = 1'b0;
    // R6: clear rise on the expiry edge
    step();
    while (m_ph != np(fast, len) - 1) step();
    clr = 1'b1; step(); clr = 1'b0;
    chk(tick_n === 1'b0, "R6", int'(tick_n), 0);
    // R8: masking
    en = 1'b0; step();
    chk(irq === 1'b0, "R8", int'(irq), 0);
    chk(stat === 1'b1, "R9", int'(stat), 1);
    en = 1'b1; step();
    chk(irq === 1'b1, "R8", int'(irq), 1);
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      step();
      if ($urandom % 1000 < 4) begin
        fast = 1'($urandom % 2);
        len  = fast ? 2'($urandom % 4) : 2'($urandom % 2);
      end
      if ($urandom % 8 == 0) clr = ~clr;
      if ($urandom % 64 == 0) en = ~en;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule